// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block stands in front of a small word-organised storage array and turns host write cycles into the multi-cycle command protocol of a parallel NOR flash. Three-step keyed sequences lead to programming, erasing and identification. A separate query mode exposes a self-description table. The sequencer also decides what a host read returns: array contents, an erase status byte, identification words or table bytes. The bus width is a parameter of 1, 2 or 4 bytes. Byte addresses are turned into device word offsets before any comparison.

The host drives single-cycle write and read strobes. Read data is registered and comes back one cycle after the strobe. Erase duration is not timed here. A companion timer sees `erase_busy_o` and answers with a one-cycle `erase_done_i` pulse. The storage is an internal flop array that starts erased (all ones). Programming can only clear bits.

Top module: `norcmd_seq`

## Requirements
- R1: After reset, `mode_o` reads 0 (read-array), `bypass_o`, `rvalid_o` and `erase_busy_o` are 0, and every array word reads as all ones.
- R2: The word offset is the byte address divided by the bus width in bytes. Only its low 11 bits are compared with the two keyed addresses (defaults 0x555 and 0x2AA), so offset bits above bit 10 do not affect the command protocol.
- R3: A command needs 0xAA at key address A, then 0x55 at key address B, then the opcode at key address A. A wrong value or address in the first two steps returns to read-array without side effects.
- R4: The accepted opcodes in the third step are 0x80 (erase), 0x90 (identify), 0xA0 (program) and 0x20 (enter bypass). Any other opcode returns to read-array with no effect.
- R5: After opcode 0xA0, the next write stores (old word AND written data) at its offset and returns to read-array. A bit never goes from 0 to 1 except by erase.
- R6: After 0x80, a second 0xAA/0x55 keyed pair is needed. Then 0x10 at key address A starts a chip erase, and 0x30 at any address starts an erase of the sector holding that offset. 0x10 anywhere else aborts. `erase_busy_o` stays high until `erase_done_i`, after which the chosen region reads all ones and the other sectors are unchanged.
- R7: While an erase runs, reads return a status byte: bit 7 = 0, bit 3 = 1, and bits 6 and 2 both start at 0 and invert after every status read. All writes, including 0xF0, are ignored.
- R8: A write of 0xF0 outside program and erase returns to read-array. From the query mode entered via identify, it returns to identify mode instead.
- R9: 0x98 written at a word offset whose low byte is 0x55 enters query mode, from read-array or from identify mode. A query read at low-byte offset k < 64 returns table byte k: 0x10..0x12 = 0x51,0x52,0x59; 0x13 = 0x02; 0x27 = log2 of array bytes; 0x2C = 1; 0x2D/0x2E = sector count minus one; 0x2F/0x30 = sector bytes shifted right by 8 and by 16. All other table bytes are 0, and offsets at 64 or beyond read 0.
- R10: In identify mode, a read at low-byte offset 0 returns ID word 0, offset 1 returns ID word 1, offset 2 returns 0x00 (no sector protected), and any other offset returns array data.
- R11: Opcode 0x20 sets bypass. While bypass is set, the third step's address is not checked. Writing 0x00 in identify mode while bypass is set clears bypass and returns to read-array.
- R12: In identify or query mode, the 43rd consecutive read with no write in between returns array data, and the block is then in read-array mode.
- R13: `rvalid_o` is high exactly one cycle after `rd_en_i`. A read uses the mode in force before a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8*BUS_BYTES | Write data; low byte carries opcodes |
| erase_done_i | input | 1 | Pulse from the erase timer ending the running erase |
| rdata_o | output | 8*BUS_BYTES | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| mode_o | output | 4 | Current command mode, 0 = read-array |
| bypass_o | output | 1 | Keyed-address bypass active |
| erase_busy_o | output | 1 | Chip or sector erase running |

## Verification
A read strobe and a command write can occur in the same cycle. In that case the read must see the mode that was in force before the write. The bench provokes this by reading an identification offset while writing 0xF0. It expects the ID word in that response and array data on the next read. It also issues a status read in the cycle before `erase_done_i`, to show that status ends exactly when erasing ends.

// File: rtl/norcmd_pkg.sv
package norcmd_pkg;

    typedef enum logic [3:0] {
        M_ARRAY       = 4'd0,
        M_KEY_A       = 4'd1,
        M_KEY_B       = 4'd2,
        M_PROG        = 4'd3,
        M_ERS_KEY_A   = 4'd4,
        M_ERS_KEY_B   = 4'd5,
        M_ERS_OP      = 4'd6,
        M_CHIP_ERS    = 4'd7,
        M_SECT_ERS    = 4'd8,
        M_IDENT       = 4'd9,
        M_QUERY       = 4'd10,
        M_IDENT_QUERY = 4'd11
    } mode_e;

    localparam logic [7:0] OP_KEY_A       = 8'hAA;
    localparam logic [7:0] OP_KEY_B       = 8'h55;
    localparam logic [7:0] OP_ERASE       = 8'h80;
    localparam logic [7:0] OP_IDENT       = 8'h90;
    localparam logic [7:0] OP_PROGRAM     = 8'hA0;
    localparam logic [7:0] OP_BYPASS      = 8'h20;
    localparam logic [7:0] OP_CHIP        = 8'h10;
    localparam logic [7:0] OP_SECTOR      = 8'h30;
    localparam logic [7:0] OP_RESET       = 8'hF0;
    localparam logic [7:0] OP_QUERY       = 8'h98;
    localparam logic [7:0] OP_BYPASS_EXIT = 8'h00;
    localparam logic [7:0] QUERY_OFFSET   = 8'h55;

    // Self-description table, computed from the geometry.
    function automatic logic [7:0] query_byte(input logic [7:0] idx,
                                              input int unsigned size_log2,
                                              input int unsigned sect_cnt,
                                              input int unsigned sect_bytes);
        logic [31:0] cnt_m1;
        logic [31:0] sb;
        logic [31:0] sl;
        cnt_m1 = 32'(sect_cnt - 1);
        sb     = 32'(sect_bytes);
        sl     = 32'(size_log2);
        case (idx)
            8'h10:   query_byte = 8'h51;
            8'h11:   query_byte = 8'h52;
            8'h12:   query_byte = 8'h59;
            8'h13:   query_byte = 8'h02;
            8'h27:   query_byte = sl[7:0];
            8'h2C:   query_byte = 8'h01;
            8'h2D:   query_byte = cnt_m1[7:0];
            8'h2E:   query_byte = cnt_m1[15:8];
            8'h2F:   query_byte = sb[15:8];
            8'h30:   query_byte = sb[23:16];
            default: query_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/norcmd_status.sv
module norcmd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       erasing_i,
    input  logic       status_rd_i,
    output logic [7:0] status_o
);

    typedef struct packed {
        logic tog_hi;
        logic tog_lo;
    } tog_t;

    tog_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!erasing_i) begin
            st_d = '0;
        end else if (status_rd_i) begin
            st_d.tog_hi = ~st_q.tog_hi;
            st_d.tog_lo = ~st_q.tog_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = {1'b0, st_q.tog_hi, 2'b00, 1'b1, st_q.tog_lo, 2'b00};

    // R7: each status read during an erase inverts the toggle bit
    p_toggle_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (erasing_i && status_rd_i) |=> (!erasing_i || status_o[6] != $past(status_o[6])));

endmodule

// File: rtl/norcmd_store.sv
module norcmd_store #(
    parameter int DW      = 16,
    parameter int ARR_AW  = 6,
    parameter int SECT_AW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      prog_i,
    input  logic [ARR_AW-1:0]         idx_i,
    input  logic [DW-1:0]             wdata_i,
    input  logic                      chip_clr_i,
    input  logic                      sect_clr_i,
    input  logic [ARR_AW-SECT_AW-1:0] sect_i,
    input  logic [ARR_AW-1:0]         ridx_i,
    output logic [DW-1:0]             rdata_o
);

    localparam int DEPTH = 2 ** ARR_AW;

    logic [DEPTH-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        logic [ARR_AW-1:0] iw;
        mem_d = mem_q;
        for (int i = 0; i < DEPTH; i++) begin
            iw = ARR_AW'(i);
            if (chip_clr_i || (sect_clr_i && iw[ARR_AW-1:SECT_AW] == sect_i)) begin
                mem_d[i] = '1;
            end else if (prog_i && idx_i == iw) begin
                mem_d[i] = mem_q[i] & wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[ridx_i];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word_chk
        // R5: without an erase no stored bit rises
        p_bits_only_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!chip_clr_i && !sect_clr_i) |=> ((mem_q[g] & ~$past(mem_q[g])) == '0));
    end

endmodule

// File: rtl/norcmd_fsm.sv
module norcmd_fsm
    import norcmd_pkg::*;
#(
    parameter int          WOFF_W     = 12,
    parameter int          ARR_AW     = 6,
    parameter int          SECT_AW    = 4,
    parameter logic [10:0] KEY_A      = 11'h555,
    parameter logic [10:0] KEY_B      = 11'h2AA,
    parameter int          LAZY_READS = 42
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic                      rd_en_i,
    input  logic [WOFF_W-1:0]         woff_i,
    input  logic [7:0]                cmd_i,
    input  logic                      erase_done_i,
    output mode_e                     mode_o,
    output logic                      bypass_o,
    output logic                      prog_fire_o,
    output logic                      chip_clr_o,
    output logic                      sect_clr_o,
    output logic [ARR_AW-SECT_AW-1:0] sect_o,
    output logic                      lazy_fire_o
);

    localparam int SECT_W = ARR_AW - SECT_AW;
    localparam int CNT_W  = $clog2(LAZY_READS + 1);

    typedef struct packed {
        mode_e             mode;
        logic              bypass;
        logic [CNT_W-1:0]  rd_cnt;
        logic [SECT_W-1:0] sect;
    } fsm_t;

    fsm_t st_d, st_q;

    logic [10:0] key;
    logic [7:0]  low;
    logic        at_a, at_b, at_query, in_query, erasing;

    always_comb begin
        key      = 11'(woff_i);
        low      = 8'(woff_i);
        at_a     = (key == KEY_A);
        at_b     = (key == KEY_B);
        at_query = (low == QUERY_OFFSET);
        in_query = (st_q.mode == M_IDENT) || (st_q.mode == M_QUERY) ||
                   (st_q.mode == M_IDENT_QUERY);
        erasing  = (st_q.mode == M_CHIP_ERS) || (st_q.mode == M_SECT_ERS);

        st_d        = st_q;
        prog_fire_o = 1'b0;
        chip_clr_o  = 1'b0;
        sect_clr_o  = 1'b0;
        lazy_fire_o = 1'b0;

        // consecutive-read fallback out of identify/query modes
        if (!in_query) begin
            st_d.rd_cnt = '0;
        end else if (rd_en_i) begin
            if (st_q.rd_cnt == CNT_W'(LAZY_READS)) begin
                lazy_fire_o = 1'b1;
                st_d.mode   = M_ARRAY;
                st_d.rd_cnt = '0;
            end else begin
                st_d.rd_cnt = st_q.rd_cnt + 1'b1;
            end
        end

        if (erasing && erase_done_i) begin
            st_d.mode  = M_ARRAY;
            chip_clr_o = (st_q.mode == M_CHIP_ERS);
            sect_clr_o = (st_q.mode == M_SECT_ERS);
        end

        if (wr_en_i && !erasing) begin
            st_d.rd_cnt = '0;
            if (cmd_i == OP_RESET && st_q.mode != M_PROG) begin
                st_d.mode = (st_q.mode == M_IDENT_QUERY) ? M_IDENT : M_ARRAY;
            end else begin
                case (st_q.mode)
                    M_ARRAY: begin
                        if (at_query && cmd_i == OP_QUERY)    st_d.mode = M_QUERY;
                        else if (at_a && cmd_i == OP_KEY_A)   st_d.mode = M_KEY_A;
                    end
                    M_KEY_A:
                        st_d.mode = (at_b && cmd_i == OP_KEY_B) ? M_KEY_B : M_ARRAY;
                    M_KEY_B: begin
                        st_d.mode = M_ARRAY;
                        if (at_a || st_q.bypass) begin
                            case (cmd_i)
                                OP_ERASE:   st_d.mode = M_ERS_KEY_A;
                                OP_IDENT:   st_d.mode = M_IDENT;
                                OP_PROGRAM: st_d.mode = M_PROG;
                                OP_BYPASS:  st_d.bypass = 1'b1;
                                default:    st_d.mode = M_ARRAY;
                            endcase
                        end
                    end
                    M_PROG: begin
                        prog_fire_o = 1'b1;
                        st_d.mode   = M_ARRAY;
                    end
                    M_ERS_KEY_A:
                        st_d.mode = (at_a && cmd_i == OP_KEY_A) ? M_ERS_KEY_B : M_ARRAY;
                    M_ERS_KEY_B:
                        st_d.mode = (at_b && cmd_i == OP_KEY_B) ? M_ERS_OP : M_ARRAY;
                    M_ERS_OP: begin
                        if (cmd_i == OP_CHIP && at_a) begin
                            st_d.mode = M_CHIP_ERS;
                        end else if (cmd_i == OP_SECTOR) begin
                            st_d.mode = M_SECT_ERS;
                            st_d.sect = woff_i[ARR_AW-1:SECT_AW];
                        end else begin
                            st_d.mode = M_ARRAY;
                        end
                    end
                    M_IDENT: begin
                        if (st_q.bypass && cmd_i == OP_BYPASS_EXIT) begin
                            st_d.bypass = 1'b0;
                            st_d.mode   = M_ARRAY;
                        end else if (at_query && cmd_i == OP_QUERY) begin
                            st_d.mode = M_IDENT_QUERY;
                        end else begin
                            st_d.mode = M_ARRAY;
                        end
                    end
                    default: st_d.mode = M_ARRAY;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_ARRAY, bypass: 1'b0, rd_cnt: '0, sect: '0};
        else        st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign bypass_o = st_q.bypass;
    assign sect_o   = st_q.sect;

    // R5: a program data write leaves program mode after one cycle
    p_prog_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_PROG && wr_en_i) |=> (st_q.mode == M_ARRAY));

    // R7: an erase only ends through the done pulse
    p_erase_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_CHIP_ERS || st_q.mode == M_SECT_ERS) && !erase_done_i)
        |=> (st_q.mode == $past(st_q.mode)));

    // R11: bypass is only left from identify mode
    p_bypass_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.bypass) |-> ($past(st_q.mode) == M_IDENT));

    // R12: the read counter never passes its limit
    p_lazy_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_cnt <= CNT_W'(LAZY_READS));

endmodule

// File: rtl/norcmd_seq.sv
module norcmd_seq
    import norcmd_pkg::*;
#(
    parameter int          BUS_BYTES  = 2,
    parameter int          ADDR_W     = 13,
    parameter int          ARR_AW     = 6,
    parameter int          SECT_WORDS = 16,
    parameter logic [10:0] KEY_A      = 11'h555,
    parameter logic [10:0] KEY_B      = 11'h2AA,
    parameter logic [15:0] ID_WORD0   = 16'h0001,
    parameter logic [15:0] ID_WORD1   = 16'h227E,
    parameter int          LAZY_READS = 42,
    parameter int          QUERY_LEN  = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic                   rd_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [8*BUS_BYTES-1:0] wdata_i,
    input  logic                   erase_done_i,
    output logic [8*BUS_BYTES-1:0] rdata_o,
    output logic                   rvalid_o,
    output logic [3:0]             mode_o,
    output logic                   bypass_o,
    output logic                   erase_busy_o
);

    localparam int DW         = 8 * BUS_BYTES;
    localparam int BSH        = $clog2(BUS_BYTES);
    localparam int WOFF_W     = ADDR_W - BSH;
    localparam int SECT_AW    = $clog2(SECT_WORDS);
    localparam int SECT_W     = ARR_AW - SECT_AW;
    localparam int SECT_CNT   = 2 ** SECT_W;
    localparam int SECT_BYTES = SECT_WORDS * BUS_BYTES;
    localparam int SIZE_LOG2  = ARR_AW + BSH;

    logic [WOFF_W-1:0] woff;
    logic [7:0]        low;
    assign woff = addr_i[ADDR_W-1:BSH];
    assign low  = 8'(woff);

    mode_e             mode;
    logic              prog_fire, chip_clr, sect_clr, lazy_fire, erasing;
    logic [SECT_W-1:0] sect;
    logic [DW-1:0]     arr_rdata;
    logic [7:0]        status;

    norcmd_fsm #(
        .WOFF_W(WOFF_W), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW),
        .KEY_A(KEY_A), .KEY_B(KEY_B), .LAZY_READS(LAZY_READS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .woff_i(woff), .cmd_i(wdata_i[7:0]), .erase_done_i(erase_done_i),
        .mode_o(mode), .bypass_o(bypass_o), .prog_fire_o(prog_fire),
        .chip_clr_o(chip_clr), .sect_clr_o(sect_clr), .sect_o(sect),
        .lazy_fire_o(lazy_fire)
    );

    norcmd_store #(.DW(DW), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .prog_i(prog_fire), .idx_i(woff[ARR_AW-1:0]),
        .wdata_i(wdata_i), .chip_clr_i(chip_clr), .sect_clr_i(sect_clr),
        .sect_i(sect), .ridx_i(woff[ARR_AW-1:0]), .rdata_o(arr_rdata)
    );

    assign erasing = (mode == M_CHIP_ERS) || (mode == M_SECT_ERS);

    norcmd_status u_status (
        .clk(clk), .rst_n(rst_n), .erasing_i(erasing),
        .status_rd_i(rd_en_i && erasing), .status_o(status)
    );

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en_i;
        if (rd_en_i) begin
            case (mode)
                M_CHIP_ERS, M_SECT_ERS: rd_d.data = DW'(status);
                M_IDENT: begin
                    if (lazy_fire)          rd_d.data = arr_rdata;
                    else if (low == 8'd0)   rd_d.data = DW'(ID_WORD0);
                    else if (low == 8'd1)   rd_d.data = DW'(ID_WORD1);
                    else if (low == 8'd2)   rd_d.data = '0;
                    else                    rd_d.data = arr_rdata;
                end
                M_QUERY, M_IDENT_QUERY: begin
                    if (lazy_fire)                   rd_d.data = arr_rdata;
                    else if (32'(low) < QUERY_LEN)
                        rd_d.data = DW'(query_byte(low, SIZE_LOG2, SECT_CNT, SECT_BYTES));
                    else                             rd_d.data = '0;
                end
                default: rd_d.data = arr_rdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o      = rd_q.data;
    assign rvalid_o     = rd_q.valid;
    assign mode_o       = 4'(mode);
    assign erase_busy_o = erasing;

    // R13: one response per strobe, one cycle later
    p_rvalid_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rvalid_o);
    p_rvalid_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rvalid_o);

    // R6: busy persists until the timer answers
    p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy_o && !erase_done_i) |=> erase_busy_o);

endmodule

// File: tb/norcmd_seq_tb_top.sv
`timescale 1ns/1ps
module norcmd_seq_tb_top;

    localparam int BB     = 2;
    localparam int ADDR_W = 13;
    localparam int KA     = 'h555;
    localparam int KB     = 'h2AA;
    localparam logic [15:0] ID0 = 16'h0001;
    localparam logic [15:0] ID1 = 16'h227E;

    logic              clk, rst_n, wr_en, rd_en, erase_done;
    logic [ADDR_W-1:0] addr;
    logic [15:0]       wdata, rdata;
    logic              rvalid, bypass, busy;
    logic [3:0]        mode;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    norcmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .erase_done_i(erase_done),
        .rdata_o(rdata), .rvalid_o(rvalid), .mode_o(mode),
        .bypass_o(bypass), .erase_busy_o(busy)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (rvalid === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R13 unexpected response: actual=%h expected=none", rdata);
            end else begin
                check(32'(rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
            end
        end
    end

    task automatic wr_w(input int w, input logic [15:0] d);
        addr  = ADDR_W'(w * BB);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_w(input int w, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr  = ADDR_W'(w * BB);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cmd3(input int a3, input logic [15:0] op);
        wr_w(KA, 16'h00AA);
        wr_w(KB, 16'h0055);
        wr_w(a3, op);
    endtask

    task automatic erase_seq(input int a, input logic [15:0] op);
        cmd3(KA, 16'h0080);
        wr_w(KA, 16'h00AA);
        wr_w(KB, 16'h0055);
        wr_w(a, op);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; erase_done = 1'b0;
        addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(32'(mode), 0, "R1 mode");
        check(32'(bypass), 0, "R1 bypass");
        check(32'(rvalid), 0, "R1 rvalid");
        check(32'(busy), 0, "R1 busy");
        rd_w(3, 16'hFFFF, "R1 erased word");

        // R5 program, AND semantics, single cycle
        cmd3(KA, 16'h00A0); wr_w(3, 16'h0F0F);
        check(32'(mode), 0, "R5 back to array");
        rd_w(3, 16'h0F0F, "R5 first program");
        cmd3(KA, 16'h00A0); wr_w(3, 16'hF0FF);
        rd_w(3, 16'h000F, "R5 AND program");

        // R2 offset bit 11 not compared
        wr_w(KA | 'h800, 16'h00AA);
        wr_w(KB | 'h800, 16'h0055);
        wr_w(KA | 'h800, 16'h00A0);
        wr_w(5, 16'h1234);
        rd_w(5, 16'h1234, "R2 high offset bits ignored");

        // R3 wrong key address aborts
        wr_w(KA, 16'h00AA); wr_w(KB + 1, 16'h0055); wr_w(KA, 16'h00A0); wr_w(6, 16'h0000);
        rd_w(6, 16'hFFFF, "R3 bad key address");

        // R4 unknown opcode
        cmd3(KA, 16'h0077);
        check(32'(mode), 0, "R4 unknown opcode mode");
        wr_w(7, 16'h0000);
        rd_w(7, 16'hFFFF, "R4 unknown opcode no program");

        // R10 identify reads
        cmd3(KA, 16'h0090);
        rd_w(0, ID0, "R10 id word 0");
        rd_w(1, ID1, "R10 id word 1");
        rd_w(2, 16'h0000, "R10 protect query");
        rd_w(5, 16'h1234, "R10 other offset array");

        // R13 read and reset write in the same cycle
        exp_q.push_back(ID0); tag_q.push_back("R13 read sees pre-write mode");
        addr = '0; wdata = 16'h00F0; rd_en = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        rd_w(0, 16'hFFFF, "R13 next read array");

        // R9 query from array
        wr_w('h55, 16'h0098);
        rd_w('h10, 16'h0051, "R9 Q");
        rd_w('h11, 16'h0052, "R9 R");
        rd_w('h12, 16'h0059, "R9 Y");
        rd_w('h13, 16'h0002, "R9 set id");
        rd_w('h27, 16'h0007, "R9 size log2");
        rd_w('h2C, 16'h0001, "R9 region count");
        rd_w('h2D, 16'h0003, "R9 sector count");
        rd_w('h50, 16'h0000, "R9 beyond table");
        wr_w(0, 16'h00F0);
        rd_w(3, 16'h000F, "R8 reset from query");

        // R8 nested query returns to identify
        cmd3(KA, 16'h0090);
        wr_w('h55, 16'h0098);
        rd_w('h10, 16'h0051, "R9 nested query");
        wr_w(0, 16'h00F0);
        rd_w(1, ID1, "R8 back to identify");
        wr_w(0, 16'h00F0);
        rd_w(1, 16'hFFFF, "R8 identify to array");

        // R12 read fallback
        cmd3(KA, 16'h0090);
        for (int i = 0; i < 42; i++) rd_w(0, ID0, "R12 before limit");
        rd_w(0, 16'hFFFF, "R12 43rd read array");
        rd_w(0, 16'hFFFF, "R12 after fallback");
        check(32'(mode), 0, "R12 mode array");

        // R6/R7 sector erase
        cmd3(KA, 16'h00A0); wr_w(20, 16'h00FF);
        erase_seq(2, 16'h0030);
        check(32'(busy), 1, "R6 sector busy");
        rd_w(9, 16'h0008, "R7 status first");
        rd_w(9, 16'h004C, "R7 status second");
        wr_w(0, 16'h00F0);
        wr_w(KA, 16'h00AA);
        check(32'(busy), 1, "R7 writes ignored");
        rd_w(9, 16'h0008, "R7 status third");
        erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
        check(32'(busy), 0, "R6 done");
        rd_w(5, 16'hFFFF, "R6 sector word 5");
        rd_w(3, 16'hFFFF, "R6 sector word 3");
        rd_w(20, 16'h00FF, "R6 other sector kept");

        // R6 chip erase with wrong address aborts, then valid
        erase_seq(KA + 1, 16'h0010);
        check(32'(busy), 0, "R6 chip erase bad address");
        erase_seq(KA, 16'h0010);
        check(32'(busy), 1, "R6 chip busy");
        erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
        rd_w(20, 16'hFFFF, "R6 chip erased");

        // R11 bypass
        cmd3(KA, 16'h0020);
        check(32'(bypass), 1, "R11 bypass set");
        cmd3('h123, 16'h00A0); wr_w(9, 16'h5555);
        rd_w(9, 16'h5555, "R11 program no address check");
        cmd3('h124, 16'h0090);
        rd_w(0, ID0, "R11 identify no address check");
        wr_w(0, 16'h0000);
        check(32'(bypass), 0, "R11 bypass cleared");
        rd_w(0, 16'hFFFF, "R11 array after exit");
        cmd3('h123, 16'h00A0); wr_w(10, 16'h0000);
        rd_w(10, 16'hFFFF, "R11 address checked again");

        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "R13 all responses seen");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule